// File: doc/BRIEF.md
# Split-Capacity Store Write Buffer

This block sits between a fast core and a slower memory bus and absorbs posted stores. The core hands over a word address and a data word on a valid/ready port. While space remains, the store is taken in the same cycle. The buffer then pushes the words out on a bus-side valid/ready port, which may throttle its ready freely. Both sides run on one clock. The block serves every kind of buffered store: bufferable, write-through and write-back regions, and whole cache lines being written out.

Storage has two limits that apply at the same time. A pool of data words holds at most 16 words, and a pool of run descriptors holds at most 4 runs. A run is a base word address plus a length. When a store hits the word just past the end of the newest run, it lengthens that run. Any other store opens a new run. Runs leave the buffer oldest first, and each run leaves lowest address first.

A load-address probe tells the cache controller whether a word it wants to read is still waiting in the buffer. A flush input holds off new stores so the buffer empties, and an empty flag marks the point where a barrier can complete.

Top module: `split_wbuf`

## Requirements
- R1: During and right after reset, `empty` is 1, `bus_valid` is 0 and `st_ready` is 1.
- R2: `st_ready` stays 1 while fewer than 16 words are held. It is 0 whenever 16 words are held, whatever the store address.
- R3: When all 4 runs are in use, a store that does not continue the newest run sees `st_ready` = 0.
- R4: A store whose word address equals the newest run's base plus its length joins that run. It is accepted even when all 4 runs are in use.
- R5: Words leave on the bus oldest run first. Inside a run they leave in ascending word address (consecutive transfers of one run step the address by 1), and each word keeps the data it was stored with.
- R6: `bus_valid` is 1 exactly when a word is held. While `bus_valid` is 1 and `bus_ready` is 0, `bus_addr` and `bus_data` hold still.
- R7: `ld_hit` is 1 when `ld_addr` equals the word address of any held word, and 0 otherwise.
- R8: While `flush` is 1, `st_ready` is 0 and no store enters. `empty` is 1 exactly when no word is held.
- R9: A store and a bus transfer in the same cycle are both honoured. This includes a store that continues a one-word run whose last word leaves in that very cycle; the store's word still leaves after it, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by core and bus sides |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer takes the store this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| bus_valid | output | 1 | A word is offered to memory |
| bus_ready | input | 1 | Memory takes the offered word |
| bus_addr | output | ADDR_W | Word address of the offered word |
| bus_data | output | DATA_W | Data of the offered word |
| ld_addr | input | ADDR_W | Word address probed for a pending store |
| ld_hit | output | 1 | Probed word is still buffered |
| flush | input | 1 | Hold off stores until drained |
| empty | output | 1 | No word buffered |

## Verification
The bench fills the run pool first and then the word pool. It confirms that a non-continuing store stalls while a continuing one still gets in. A design that checked only one of the two limits would either overrun a pool or stall too early. It covers the case where a store joins a one-word run in the same cycle that run's last word leaves. A design that freed the run there would lose the word or send it with a stale address. The bench also drains with a throttled `bus_ready` and probes addresses just past the end of a run. This catches off-by-one errors in the hit range and payloads that change while the bus is stalled.

// File: rtl/split_wbuf.sv
module split_wbuf #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 16,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  input  logic              flush,
  output logic              empty
);
  localparam int WPW = $clog2(WORDS);
  localparam int EPW = $clog2(ENTRIES);
  localparam int CW  = $clog2(WORDS + 1);
  localparam int ECW = $clog2(ENTRIES + 1);

  logic [DATA_W-1:0] mem  [WORDS];
  logic [ADDR_W-1:0] ebase[ENTRIES];
  logic [CW-1:0]     elen [ENTRIES];
  logic [WPW-1:0]    wp, rp;
  logic [EPW-1:0]    eh, et, newest;
  logic [CW-1:0]     wcnt;
  logic [ECW-1:0]    ecnt;

  logic can_merge, st_fire, bus_fire, merge, new_entry, head_pop;

  assign newest    = et - 1'b1;
  assign can_merge = (ecnt != '0) && (st_addr == ebase[newest] + ADDR_W'(elen[newest]));
  assign st_ready  = !flush && (wcnt < CW'(WORDS)) && (can_merge || ecnt < ECW'(ENTRIES));
  assign st_fire   = st_valid && st_ready;
  assign merge     = st_fire && can_merge;
  assign new_entry = st_fire && !can_merge;
  assign bus_valid = (ecnt != '0);
  assign bus_fire  = bus_valid && bus_ready;
  assign bus_addr  = ebase[eh];
  assign bus_data  = mem[rp];
  assign empty     = (ecnt == '0);
  assign head_pop  = bus_fire && (elen[eh] == CW'(1)) && !(merge && eh == newest);

  always_comb begin
    ld_hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic [EPW-1:0] rel;
      rel = EPW'(i) - eh;
      if ((ECW'(rel) < ecnt) && ((ld_addr - ebase[i]) < ADDR_W'(elen[i])))
        ld_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; eh <= '0; et <= '0;
      wcnt <= '0; ecnt <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        elen[i]  <= '0;
        ebase[i] <= '0;
      end
    end else begin
      if (st_fire) begin
        mem[wp] <= st_data;
        wp <= wp + 1'b1;
      end
      if (bus_fire) rp <= rp + 1'b1;
      wcnt <= wcnt + CW'(st_fire) - CW'(bus_fire);
      for (int i = 0; i < ENTRIES; i++) begin
        if (new_entry && EPW'(i) == et) begin
          ebase[i] <= st_addr;
          elen[i]  <= CW'(1);
        end else begin
          elen[i]  <= elen[i] + CW'(merge && EPW'(i) == newest)
                              - CW'(bus_fire && EPW'(i) == eh);
          ebase[i] <= ebase[i] + ADDR_W'(bus_fire && EPW'(i) == eh);
        end
      end
      eh   <= eh + EPW'(head_pop);
      et   <= et + EPW'(new_entry);
      ecnt <= ecnt + ECW'(new_entry) - ECW'(head_pop);
    end
  end

  // R2
  word_pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(WORDS));
  // R3
  entry_pool_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= ECW'(ENTRIES));
  // R5
  run_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fire && elen[eh] > CW'(1) |=> bus_valid && bus_addr == $past(bus_addr) + 1'b1);
  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data));
  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && empty |=> empty);
  // R9
  word_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire && bus_fire |=> wcnt == $past(wcnt));
endmodule

// File: tb/split_wbuf_tb.sv
module split_wbuf_tb;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, bus_ready = 0, flush = 0;
  logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
  logic st_ready, bus_valid, ld_hit, empty;
  logic [31:0] bus_addr, bus_data;

  int checks = 0, fails = 0;
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  int lcount = 0;
  logic [31:0] exp_a [16];
  logic [31:0] exp_d [16];

  localparam logic [63:0] VEC [8] = '{
    {32'h100, 32'hA000_0001}, {32'h101, 32'hA000_0002}, {32'h102, 32'hA000_0003},
    {32'h200, 32'hB000_0001}, {32'h050, 32'hC000_0001}, {32'h051, 32'hC000_0002},
    {32'h300, 32'hD000_0001}, {32'h301, 32'hD000_0002}};

  split_wbuf u_dut (.clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_data(bus_data), .ld_addr(ld_addr), .ld_hit(ld_hit),
    .flush(flush), .empty(empty));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    #2;
    if (rst_n && bus_valid && bus_ready && lcount < 64) begin
      log_a[lcount] = bus_addr;
      log_d[lcount] = bus_data;
      lcount++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_try(input logic [31:0] a, input logic [31:0] d, input logic er, input string tag);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d;
    #1 chk(tag, st_ready, er);
    @(posedge clk);
  endtask

  task automatic drain_all(input bit thr);
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (empty) break;
      bus_ready = thr ? n[0] : 1'b1;
    end
    bus_ready = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 empty", empty, 1); chk("R1 bus_valid", bus_valid, 0); chk("R1 st_ready", st_ready, 1);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      push_try(VEC[i][63:32], VEC[i][31:0], 1, "R2 accept with space");
      exp_a[i] = VEC[i][63:32]; exp_d[i] = VEC[i][31:0];
    end
    push_try(32'h400, 32'hE000_0000, 0, "R3 run pool full stall");
    push_try(32'h302, 32'hD000_0003, 1, "R4 merge while runs full");
    exp_a[8] = 32'h302; exp_d[8] = 32'hD000_0003;
    for (int i = 0; i < 7; i++) begin
      push_try(32'h303 + i, 32'hD100_0000 + i, 1, "R4 merge run");
      exp_a[9+i] = 32'h303 + i; exp_d[9+i] = 32'hD100_0000 + i;
    end
    push_try(32'h30A, 32'hF000_0000, 0, "R2 word pool full stall");
    @(negedge clk); st_valid = 0;
    #1 chk("R6 valid when held", bus_valid, 1);
    chk("R8 not empty", empty, 0);
    ld_addr = 32'h101; #1 chk("R7 hit mid run", ld_hit, 1);
    ld_addr = 32'h103; #1 chk("R7 miss past run", ld_hit, 0);
    ld_addr = 32'h309; #1 chk("R7 hit run end", ld_hit, 1);
    ld_addr = 32'h30A; #1 chk("R7 miss after end", ld_hit, 0);
    ld_addr = 32'h04F; #1 chk("R7 miss before base", ld_hit, 0);
    lcount = 0;
    drain_all(1);
    chk("R5 drained count", lcount, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R5 drain addr", log_a[i], exp_a[i]);
      chk("R5 drain data", log_d[i], exp_d[i]);
    end
    #1 chk("R8 empty after drain", empty, 1);
    chk("R6 valid low when empty", bus_valid, 0);
    ld_addr = 32'h101; #1 chk("R7 miss when empty", ld_hit, 0);

    lcount = 0;
    bus_ready = 1;
    push_try(32'h500, 32'h5555_0000, 1, "R9 store with drain");
    push_try(32'h501, 32'h5555_0001, 1, "R9 merge into leaving run");
    push_try(32'h502, 32'h5555_0002, 1, "R9 merge again");
    @(negedge clk); st_valid = 0;
    drain_all(0);
    chk("R9 count", lcount, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R9 addr", log_a[i], 32'h500 + i);
      chk("R9 data", log_d[i], 32'h5555_0000 + i);
    end

    lcount = 0;
    bus_ready = 0;
    push_try(32'h800, 32'h8888_0000, 1, "R8 pre-flush store");
    push_try(32'h900, 32'h9999_0000, 1, "R8 pre-flush store");
    @(negedge clk); st_valid = 0; flush = 1;
    #1 chk("R8 flush stalls", st_ready, 0);
    chk("R8 not empty in flush", empty, 0);
    drain_all(1);
    #1 chk("R8 empty after flush", empty, 1);
    chk("R8 flush still stalls", st_ready, 0);
    chk("R5 flush order a0", log_a[0], 32'h800);
    chk("R5 flush order a1", log_a[1], 32'h900);
    flush = 0;
    #1 chk("R2 ready after flush", st_ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule